// File: doc/BRIEF.md
# Function Event Mailbox

A host bridge collects events about its attached functions and holds them in this mailbox until software asks for them. Producers post one of two event kinds: a fault report, or a change in a function's availability. Every posting carries a function handle, a function identifier and a 16-bit event code. A fault report also carries the faulting address and a 32-bit qualifier word. Each accepted posting sends a one-cycle pulse to the channel subsystem, which tells software that something is waiting.

On the consumer side, a level output shows whether anything is queued. A retrieve request removes the oldest entry and presents it as a record. Every multi-byte field of the record is in big-endian byte order, and the record is tagged with its kind code and a notification type. If a retrieve finds the mailbox empty, it returns a nonzero "nothing there" status and a blank record. The capacity is a parameter. A posting that arrives when the mailbox is full is lost, and a sticky flag records the loss. A posting with an unknown kind code is refused and reported.

Top module: `fn_event_queue`

## Requirements
- R1: Records leave in the order their postings were accepted, oldest first.
- R2: After a retrieve that finds an entry, `get_status` is 0 and `rec_ntype` is 2. `rec_kind` carries the posted kind code: 1 for a fault report, 2 for an availability change.
- R3: A fault record presents all five fields (identifier, handle, qualifier, address, code) with their byte order reversed. Bits [7:0] of each output field hold the most significant byte of the posted value.
- R4: An availability record presents the identifier, handle and code byte-reversed as in R3. `rec_qual` and `rec_addr` are 0, whatever was driven on those inputs at posting time.
- R5: A retrieve from an empty mailbox sets `get_status` to 1 and clears every record field, including `rec_ntype` and `rec_kind`, to 0.
- R6: `pending` is 1 exactly when the mailbox holds at least one entry. It reflects each accepted posting or retrieve from the cycle after the clock edge that takes it.
- R7: `notify` is high for exactly the one cycle after each clock edge that accepts a posting, and is low otherwise.
- R8: A legal posting that arrives while the mailbox holds `DEPTH` entries is dropped, even if a retrieve happens in the same cycle. Such a posting raises no `notify` and sets `overflow`, which stays 1 until reset.
- R9: A posting with kind code 0 or 3 is never stored and raises no `notify`. It pulses `bad_kind` for the one cycle after its edge and does not touch `overflow`, even when the mailbox is full.
- R10: After reset the mailbox is empty, and `pending`, `notify`, `bad_kind`, `overflow`, `get_done`, `get_status` and every record field are 0.
- R11: `get_done` is high for the cycle after each edge that samples `get_req`. The record and status outputs hold their values until the next retrieve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Posting strobe |
| post_kind | input | 2 | Kind code: 1 fault, 2 availability |
| post_handle | input | 32 | Function handle |
| post_fid | input | 32 | Function identifier |
| post_code | input | 16 | Event code |
| post_addr | input | 64 | Faulting address (fault only) |
| post_qual | input | 32 | Qualifier word (fault only) |
| notify | output | 1 | One-cycle pulse per accepted posting |
| bad_kind | output | 1 | One-cycle pulse for a refused kind code |
| overflow | output | 1 | Sticky: a posting was lost to a full mailbox |
| pending | output | 1 | Mailbox not empty |
| get_req | input | 1 | Retrieve request |
| get_done | output | 1 | Retrieve result valid this cycle |
| get_status | output | 1 | 0 record returned, 1 nothing queued |
| rec_ntype | output | 8 | Notification type of the record |
| rec_kind | output | 8 | Kind code of the record |
| rec_fid | output | 32 | Identifier, big-endian |
| rec_handle | output | 32 | Handle, big-endian |
| rec_qual | output | 32 | Qualifier, big-endian |
| rec_addr | output | 64 | Faulting address, big-endian |
| rec_code | output | 16 | Event code, big-endian |

## Verification
The hardest case to reach is a posting that arrives on a full mailbox in the same cycle as a retrieve. Random traffic that retrieves about as often as it posts almost never fills all the slots. The bench therefore has a directed phase that posts past capacity with retrieves held off, then posts and retrieves together while full. It follows this with a random phase in which postings outnumber retrieves, so the full boundary is crossed again and again. Availability postings always drive nonzero address and qualifier values, so a record that leaks either field shows up at the outputs.

// File: rtl/evq_pkg.sv
package evq_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_FAULT = 2'd1,
    KIND_AVAIL = 2'd2,
    KIND_RSVD  = 2'd3
  } evq_kind_e;

  typedef struct packed {
    evq_kind_e   kind;
    logic [31:0] handle;
    logic [31:0] fid;
    logic [15:0] code;
    logic [63:0] addr;
    logic [31:0] qual;
  } evq_entry_t;

  typedef struct packed {
    logic [7:0]  ntype;
    logic [7:0]  kind;
    logic [31:0] fid;
    logic [31:0] handle;
    logic [31:0] qual;
    logic [63:0] addr;
    logic [15:0] code;
  } evq_rec_t;

  localparam logic [7:0] REC_NTYPE = 8'd2;

  function automatic logic kind_legal(input logic [1:0] k);
    return (k == KIND_FAULT) || (k == KIND_AVAIL);
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 2; i++) r[8*i +: 8] = v[8*(1-i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = v[8*(3-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/evq_store.sv
module evq_store
  import evq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  evq_entry_t wr_data,
  input  logic       rd_en,
  output evq_entry_t head,
  output logic       full,
  output logic       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  evq_entry_t    slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = slots[rd_ptr];
  assign full  = (count == CAP);
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP); // R8
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R8
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R1
endmodule

// File: rtl/evq_format.sv
module evq_format
  import evq_pkg::*;
(
  input  evq_entry_t ent,
  output evq_rec_t   rec
);
  logic is_fault;
  assign is_fault = (ent.kind == KIND_FAULT);

  always_comb begin
    rec        = '0;
    rec.ntype  = REC_NTYPE;
    rec.kind   = {6'd0, ent.kind};
    rec.fid    = rev32(ent.fid);
    rec.handle = rev32(ent.handle);
    rec.code   = rev16(ent.code);
    rec.qual   = is_fault ? rev32(ent.qual) : '0;
    rec.addr   = is_fault ? rev64(ent.addr) : '0;
  end
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
  import evq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        post_valid,
  input  logic [1:0]  post_kind,
  input  logic [31:0] post_handle,
  input  logic [31:0] post_fid,
  input  logic [15:0] post_code,
  input  logic [63:0] post_addr,
  input  logic [31:0] post_qual,
  output logic        notify,
  output logic        bad_kind,
  output logic        overflow,
  output logic        pending,
  input  logic        get_req,
  output logic        get_done,
  output logic        get_status,
  output logic [7:0]  rec_ntype,
  output logic [7:0]  rec_kind,
  output logic [31:0] rec_fid,
  output logic [31:0] rec_handle,
  output logic [31:0] rec_qual,
  output logic [63:0] rec_addr,
  output logic [15:0] rec_code
);
  evq_entry_t in_ent, head;
  evq_rec_t   fmt_rec, rec_q;
  logic       full, empty;
  logic       legal, accept, drop_full, refuse, take;

  assign legal     = kind_legal(post_kind);
  assign accept    = post_valid && legal && !full;
  assign drop_full = post_valid && legal && full;
  assign refuse    = post_valid && !legal;
  assign take      = get_req && !empty;

  always_comb begin
    in_ent        = '0;
    in_ent.kind   = evq_kind_e'(post_kind);
    in_ent.handle = post_handle;
    in_ent.fid    = post_fid;
    in_ent.code   = post_code;
    in_ent.addr   = post_addr;
    in_ent.qual   = post_qual;
  end

  evq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (in_ent),
    .rd_en   (take),
    .head    (head),
    .full    (full),
    .empty   (empty)
  );

  evq_format u_format (
    .ent (head),
    .rec (fmt_rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify     <= 1'b0;
      bad_kind   <= 1'b0;
      overflow   <= 1'b0;
      get_done   <= 1'b0;
      get_status <= 1'b0;
      rec_q      <= '0;
    end else begin
      notify   <= accept;
      bad_kind <= refuse;
      overflow <= overflow | drop_full;
      get_done <= get_req;
      if (get_req) begin
        get_status <= !take;
        rec_q      <= take ? fmt_rec : '0;
      end
    end
  end

  assign pending    = !empty;
  assign rec_ntype  = rec_q.ntype;
  assign rec_kind   = rec_q.kind;
  assign rec_fid    = rec_q.fid;
  assign rec_handle = rec_q.handle;
  assign rec_qual   = rec_q.qual;
  assign rec_addr   = rec_q.addr;
  assign rec_code   = rec_q.code;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(post_valid && full)); // R8
  AST_NOTIFY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(post_valid && !full)); // R7
  AST_BAD_NO_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind |-> !notify); // R9
  AST_EMPTY_GET: assert property (@(posedge clk) disable iff (!rst_n)
    (get_done && $past(empty)) |-> (get_status && rec_ntype == 8'd0)); // R5
  AST_GOOD_GET_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (get_done && !get_status) |-> (rec_ntype == REC_NTYPE)); // R2
  AST_AVAIL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (get_done && rec_kind == 8'd2) |-> (rec_addr == '0 && rec_qual == '0)); // R4
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !get_done |-> $stable(rec_fid)); // R11
endmodule

// File: tb/tb_fn_event_queue.sv
module tb_fn_event_queue;
  localparam int DEPTH = 8;

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] handle, fid, qual;
    logic [15:0] code;
    logic [63:0] addr;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic post_valid = 1'b0, get_req = 1'b0;
  logic [1:0] post_kind = '0;
  logic [31:0] post_handle = '0, post_fid = '0, post_qual = '0;
  logic [15:0] post_code = '0;
  logic [63:0] post_addr = '0;
  logic notify, bad_kind, overflow, pending, get_done, get_status;
  logic [7:0] rec_ntype, rec_kind;
  logic [31:0] rec_fid, rec_handle, rec_qual;
  logic [63:0] rec_addr;
  logic [15:0] rec_code;

  int checks = 0, errors = 0;
  ev_t mq[$];
  logic m_ovf = 1'b0;
  logic [7:0] x_nt = '0, x_kind = '0;
  logic [31:0] x_fid = '0, x_handle = '0, x_qual = '0;
  logic [63:0] x_addr = '0;
  logic [15:0] x_code = '0;
  logic x_status = 1'b0;

  always #10 clk = ~clk;

  fn_event_queue #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] be32(input logic [31:0] v);
    return {<<8{v}};
  endfunction
  function automatic logic [63:0] be64(input logic [63:0] v);
    return {<<8{v}};
  endfunction
  function automatic logic [15:0] be16(input logic [15:0] v);
    return {<<8{v}};
  endfunction

  task automatic step(input logic pv, input ev_t e, input logic pr);
    logic legal, acc, drop, bad, ok;
    @(negedge clk);
    post_valid = pv; post_kind = e.kind; post_handle = e.handle; post_fid = e.fid;
    post_code = e.code; post_addr = e.addr; post_qual = e.qual; get_req = pr;
    legal = (e.kind == 2'd1) || (e.kind == 2'd2);
    acc  = pv && legal && (mq.size() < DEPTH);
    drop = pv && legal && (mq.size() >= DEPTH);
    bad  = pv && !legal;
    ok   = pr && (mq.size() > 0);
    if (pr) begin
      x_status = !ok;
      if (ok) begin
        ev_t h = mq.pop_front();
        x_nt = 8'd2; x_kind = {6'd0, h.kind};
        x_fid = be32(h.fid); x_handle = be32(h.handle); x_code = be16(h.code);
        x_qual = (h.kind == 2'd1) ? be32(h.qual) : '0;
        x_addr = (h.kind == 2'd1) ? be64(h.addr) : '0;
      end else begin
        x_nt = '0; x_kind = '0; x_fid = '0; x_handle = '0; x_code = '0; x_qual = '0; x_addr = '0;
      end
    end
    if (acc) mq.push_back(e);
    m_ovf = m_ovf | drop;
    @(posedge clk); #5;
    chk(notify == acc, "R7 notify", 64'(notify), 64'(acc));
    chk(bad_kind == bad, "R9 bad_kind", 64'(bad_kind), 64'(bad));
    chk(overflow == m_ovf, "R8 overflow", 64'(overflow), 64'(m_ovf));
    chk(pending == (mq.size() != 0), "R6 pending", 64'(pending), 64'(mq.size() != 0));
    chk(get_done == pr, "R11 get_done", 64'(get_done), 64'(pr));
    chk(get_status == x_status, "R5 get_status", 64'(get_status), 64'(x_status));
    chk(rec_ntype == x_nt && rec_kind == x_kind, "R2 ntype/kind",
        64'({rec_ntype, rec_kind}), 64'({x_nt, x_kind}));
    chk(rec_fid == x_fid && rec_handle == x_handle, "R1 R3 fid/handle",
        {rec_fid, rec_handle}, {x_fid, x_handle});
    chk(rec_code == x_code && rec_qual == x_qual, "R3 code/qual",
        64'({rec_code, rec_qual}), 64'({x_code, x_qual}));
    chk(rec_addr == x_addr, "R4 addr", rec_addr, x_addr);
  endtask

  function automatic ev_t mk(input logic [1:0] k);
    ev_t e;
    e.kind = k; e.handle = $urandom; e.fid = $urandom; e.code = 16'($urandom);
    e.addr = {$urandom, $urandom} | 64'h1; e.qual = $urandom | 32'h1;
    return e;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ev_t idle;
    void'($urandom(32'hC0FFEE));
    idle = mk(2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(!pending && !notify && !bad_kind && !overflow && !get_done && !get_status,
        "R10 flags", 64'({pending, notify, bad_kind, overflow, get_done, get_status}), 64'd0);
    chk(rec_ntype == 0 && rec_fid == 0 && rec_addr == 0, "R10 record", rec_addr, 64'd0);
    // R3 R4 directed: one fault, one availability with nonzero addr/qual
    step(1'b1, mk(2'd1), 1'b0);
    step(1'b1, mk(2'd2), 1'b0);
    step(1'b0, idle, 1'b1);
    step(1'b0, idle, 1'b0);   // R11 hold
    step(1'b0, idle, 1'b1);
    step(1'b0, idle, 1'b1);   // R5 empty retrieve
    // R9 refused kinds
    step(1'b1, mk(2'd0), 1'b0);
    step(1'b1, mk(2'd3), 1'b0);
    // R8 fill past capacity, then post and retrieve together while full
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, mk(2'(1 + (i % 2))), 1'b0);
    step(1'b1, mk(2'd3), 1'b0);   // R9 refused while full, overflow unchanged
    step(1'b1, mk(2'd1), 1'b1);   // R8 dropped despite retrieve
    step(1'b1, mk(2'd2), 1'b0);
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, idle, 1'b1);   // R1 drain order
    // random phase, posts outnumber retrieves
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] k;
      k = ($urandom % 8 == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + $urandom % 2);
      step(($urandom % 4) != 0, mk(k), ($urandom % 3) == 0);
    end
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, idle, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule